// File: doc/BRIEF.md
# Hypervisor Queue and Trap-Level Interrupt Logic

This block keeps the pointer registers of four hypervisor message queues: CPU mondo, device mondo, resumable error and non-resumable error. It also keeps a hypervisor interrupt-pending register and a hyper-privileged state register, and it turns the contents of these registers into interrupt request lines. The queue memory lives elsewhere. Software moves a queue's head or tail through the register port, and the block raises that queue's request for as long as the two pointers differ. The non-resumable error queue never raises a request.

The trap-level-zero request combines three conditions: an enable bit in the state register, a clear hyper-privileged bit in that register, and a trap level input equal to zero. The request follows the trap level input directly, so it updates without any register write.

The register port is a plain control interface with no back-pressure. A write takes effect at the clock edge on which `wr_en` is high. Reads are combinational from `rd_addr` and reflect the stored values.

Top module: `hv_irq_regs`

## Requirements
- R1: Register addresses are: 0/1 CPU mondo head/tail, 2/3 device mondo head/tail, 4/5 resumable error head/tail, 6/7 non-resumable error head/tail, 8 interrupt-pending, 9 state. For the CPU mondo, device mondo and resumable error queues, the request output is high exactly when the stored head differs from the stored tail, compared over all 64 bits.
- R2: Writes to addresses 6 and 7 are stored and can be read back, but they never cause any request output to change.
- R3: After a write to either the head or the tail of a queue, that queue's request reflects the new pointer pair from the next cycle on.
- R4: `hint_req` is high exactly when the stored interrupt-pending register (address 8) is nonzero.
- R5: Every write to the state register (address 9) stores the write data with bit 11, the implementation-identification bit, forced to 1.
- R6: `tlz_req` is high exactly when state bit 0 (trap-level-zero enable) is 1, state bit 2 (hyper-privileged) is 0, and `trap_level` equals 0.
- R7: After reset, every register reads 0, except the state register, which reads 0x800. All request outputs are low.
- R8: A read of addresses 0 to 8 returns the last 64-bit value written there.
- R9: A change of `trap_level` alone updates `tlz_req` in the same cycle, with no register write.
- R10: Addresses 10 to 15 read as 0. Writes to them change no register and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 64 | Combinational read data |
| trap_level | input | 3 | Current trap level |
| cpu_mondo_req | output | 1 | CPU mondo queue non-empty |
| dev_mondo_req | output | 1 | Device mondo queue non-empty |
| res_err_req | output | 1 | Resumable error queue non-empty |
| hint_req | output | 1 | Hypervisor interrupt pending |
| tlz_req | output | 1 | Trap-level-zero request |

## Verification
The embedded assertions check several rules on every clock cycle:
- a head or tail write that makes the pointers match or mismatch moves the request one cycle later;
- writes to the non-resumable error queue leave every queue request unchanged;
- a nonzero interrupt-pending write raises `hint_req`;
- the identification bit stays at 1;
- `tlz_req` is never high at a nonzero trap level.

Only the bench scenarios show full-width read-back, the ignored writes to unmapped addresses, the reset values, and the `tlz_req` change caused by the trap level alone. The bench checks these against a register model over random mixes of matching and mismatching pointer values.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_Q  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CPU_HD  = 4'd0,
    RA_CPU_TL  = 4'd1,
    RA_DEV_HD  = 4'd2,
    RA_DEV_TL  = 4'd3,
    RA_RES_HD  = 4'd4,
    RA_RES_TL  = 4'd5,
    RA_NRES_HD = 4'd6,
    RA_NRES_TL = 4'd7,
    RA_HINT    = 4'd8,
    RA_STATE   = 4'd9
  } reg_addr_e;

  // Queue index that never raises a request
  localparam int SILENT_Q = 3;
endpackage

// File: rtl/hv_queue_ptrs.sv
module hv_queue_ptrs #(
  parameter int DATA_W  = 64,
  parameter bit GEN_REQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_head,
  input  logic              wr_tail,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head_q,
  output logic [DATA_W-1:0] tail_q,
  output logic              req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (wr_head) head_q <= wr_data;
      if (wr_tail) tail_q <= wr_data;
    end
  end

  generate
    if (GEN_REQ) begin : g_req
      assign req = (head_q != tail_q);

      // R3: head written equal to tail clears the request next cycle
      a_r3_head_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_head && !wr_tail && wr_data == tail_q) |=> !req);
      // R1: tail written different from head raises the request next cycle
      a_r1_tail_mismatch_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tail && !wr_head && wr_data != head_q) |=> req);
    end else begin : g_silent
      assign req = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hv_hpstate.sv
module hv_hpstate #(
  parameter int DATA_W      = 64,
  parameter int TL_W        = 3,
  parameter int TLZ_EN_BIT  = 0,
  parameter int HPRIV_BIT   = 2,
  parameter int IMPL_ID_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TL_W-1:0]   trap_level,
  output logic [DATA_W-1:0] state_q,
  output logic              tlz_req
);

  localparam logic [DATA_W-1:0] ID_MASK = DATA_W'(1) << IMPL_ID_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= ID_MASK;
    else if (wr) state_q <= wr_data | ID_MASK;
  end

  assign tlz_req = state_q[TLZ_EN_BIT] && !state_q[HPRIV_BIT] && (trap_level == '0);

  // R5: any state write leaves the identification bit set
  a_r5_id_forced: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> state_q[IMPL_ID_BIT]);
  // R6: no trap-level-zero request at a nonzero trap level
  a_r6_tl_nonzero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_level != '0) |-> !tlz_req);

endmodule

// File: rtl/hv_irq_regs.sv
module hv_irq_regs
  import hv_irq_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int TL_W        = 3,
  parameter int TLZ_EN_BIT  = 0,
  parameter int HPRIV_BIT   = 2,
  parameter int IMPL_ID_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [TL_W-1:0]   trap_level,
  output logic              cpu_mondo_req,
  output logic              dev_mondo_req,
  output logic              res_err_req,
  output logic              hint_req,
  output logic              tlz_req
);

  localparam int QIDX_W = $clog2(NUM_Q);
  localparam int QREG_N = 2 * NUM_Q;

  logic [DATA_W-1:0] head_arr [NUM_Q];
  logic [DATA_W-1:0] tail_arr [NUM_Q];
  logic [NUM_Q-1:0]  q_req;
  logic [DATA_W-1:0] hint_q;
  logic [DATA_W-1:0] state_q;

  genvar q;
  generate
    for (q = 0; q < NUM_Q; q++) begin : g_q
      logic sel_hd, sel_tl;
      assign sel_hd = wr_en && (wr_addr == ADDR_W'(2*q));
      assign sel_tl = wr_en && (wr_addr == ADDR_W'(2*q+1));
      hv_queue_ptrs #(.DATA_W(DATA_W), .GEN_REQ(q != SILENT_Q)) u_q (
        .clk(clk), .rst_n(rst_n), .wr_head(sel_hd), .wr_tail(sel_tl),
        .wr_data(wr_data), .head_q(head_arr[q]), .tail_q(tail_arr[q]), .req(q_req[q])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hint_q <= '0;
    else if (wr_en && wr_addr == RA_HINT) hint_q <= wr_data;
  end

  hv_hpstate #(
    .DATA_W(DATA_W), .TL_W(TL_W), .TLZ_EN_BIT(TLZ_EN_BIT),
    .HPRIV_BIT(HPRIV_BIT), .IMPL_ID_BIT(IMPL_ID_BIT)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_addr == RA_STATE),
    .wr_data(wr_data), .trap_level(trap_level), .state_q(state_q), .tlz_req(tlz_req)
  );

  assign cpu_mondo_req = q_req[0];
  assign dev_mondo_req = q_req[1];
  assign res_err_req   = q_req[2];
  assign hint_req      = |hint_q;

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < QREG_N) begin
      if (rd_addr[0]) rd_data = tail_arr[rd_addr[QIDX_W:1]];
      else            rd_data = head_arr[rd_addr[QIDX_W:1]];
    end else if (rd_addr == RA_HINT) begin
      rd_data = hint_q;
    end else if (rd_addr == RA_STATE) begin
      rd_data = state_q;
    end
  end

  // R2: writes to the silent queue never move a queue request
  a_r2_nres_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == RA_NRES_HD || wr_addr == RA_NRES_TL))
      |=> $stable({cpu_mondo_req, dev_mondo_req, res_err_req}));
  // R4: nonzero interrupt-pending write raises hint_req
  a_r4_hint_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_HINT && wr_data != '0) |=> hint_req);

endmodule

// File: tb/test_hv_irq_regs.sv
`timescale 1ns/1ps
module test_hv_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [2:0]  trap_level = '0;
  logic cpu_mondo_req, dev_mondo_req, res_err_req, hint_req, tlz_req;

  int checks = 0;
  int failures = 0;
  logic [63:0] mdl [10];

  always #2.5 clk = ~clk;

  hv_irq_regs i_hv_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trap_level(trap_level),
    .cpu_mondo_req(cpu_mondo_req), .dev_mondo_req(dev_mondo_req),
    .res_err_req(res_err_req), .hint_req(hint_req), .tlz_req(tlz_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_tlz(input logic [2:0] tl);
    return mdl[9][0] && !mdl[9][2] && (tl == 3'd0);
  endfunction

  function automatic logic [63:0] exp_rd(input logic [3:0] a);
    return (a < 4'd10) ? mdl[a] : 64'd0;
  endfunction

  // Write at a negedge; results settle after the next posedge
  task automatic do_write(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd9) mdl[9] = d | 64'h800;
    else if (a < 4'd10) mdl[a] = d;
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R1 cpu_mondo_req"}, 64'(cpu_mondo_req), 64'(mdl[0] != mdl[1]));
    chk({ctx, " R1 dev_mondo_req"}, 64'(dev_mondo_req), 64'(mdl[2] != mdl[3]));
    chk({ctx, " R3 res_err_req"},   64'(res_err_req),   64'(mdl[4] != mdl[5]));
    chk({ctx, " R4 hint_req"},      64'(hint_req),      64'(mdl[8] != 64'd0));
    chk({ctx, " R6 tlz_req"},       64'(tlz_req),       64'(exp_tlz(trap_level)));
  endtask

  function automatic logic [63:0] pick_data();
    case ($urandom_range(0, 3))
      0: return 64'd0;
      1: return 64'd5;
      2: return 64'h8000_0000_0000_0005;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 10; i++) mdl[i] = 64'd0;
    mdl[9] = 64'h800;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset values
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #0.1;
      chk("R7 reset read", rd_data, (a == 9) ? 64'h800 : 64'd0);
    end
    check_all("R7 reset");

    // R5 state write of zero keeps identification bit
    do_write(4'd9, 64'd0);
    rd_addr = 4'd9; #0.1;
    chk("R5 state id forced", rd_data, 64'h800);

    // R2 non-resumable queue mismatch raises nothing
    do_write(4'd6, 64'd7);
    check_all("R2 nres head");
    rd_addr = 4'd6; #0.1;
    chk("R2 nres readback", rd_data, 64'd7);

    // R1 top bit only mismatch
    do_write(4'd1, 64'h8000_0000_0000_0000);
    check_all("R1 msb mismatch");
    do_write(4'd0, 64'h8000_0000_0000_0000);
    check_all("R3 head catches up");

    // R9 trap level alone moves tlz_req
    do_write(4'd9, 64'h1);
    trap_level = 3'd2; #0.1;
    chk("R9 tl nonzero", 64'(tlz_req), 64'd0);
    trap_level = 3'd0; #0.1;
    chk("R9 tl zero", 64'(tlz_req), 64'd1);
    do_write(4'd9, 64'h5);
    check_all("R6 hpriv blocks");

    // R10 unmapped writes ignored
    do_write(4'd12, 64'hFFFF);
    check_all("R10 unmapped write");
    rd_addr = 4'd12; #0.1;
    chk("R10 unmapped read", rd_data, 64'd0);

    for (int n = 0; n < 400; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 11));
      if ($urandom_range(0, 3) == 0) trap_level = 3'($urandom_range(0, 3));
      if (a == 4'd9) do_write(a, 64'($urandom_range(0, 7)));
      else           do_write(a, pick_data());
      check_all("rand");
      rd_addr = 4'($urandom_range(0, 15)); #0.1;
      chk("R8 random read", rd_data, exp_rd(rd_addr));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule